// File: doc/BRIEF.md
# Synchronous Burst SRAM Cycle Controller

This block is the clocked control front end of a pipelined, single-cycle-deselect synchronous burst SRAM. On every rising clock edge it looks at three chip enables, two address strobes (one meant for a processor, one for a memory controller), an advance input, a global write, a byte-write enable, two byte-write selects and a sleep input. From these it classifies the cycle as deselect, sleep, begin read, begin write, continue burst or suspend burst. It then drives the array read and write strobes, the per-byte write enables and the array address.

A burst sequencer supplies the array address inside a burst. It counts in either linear or interleaved order over the two low address bits. A small 18-bit word store stands in for the array, so the read path can be checked end to end. Read data passes through one output register. The data-bus drive enable is gated without a clock by the output-enable input. That gate is masked during writes and during sleep.

The processor strobe always starts a read. A write on that burst can only happen on a later continue or suspend clock. The controller strobe starts a write whenever the write condition holds.

Top module: `sbsram_ctl`

## Requirements
- R1: The part counts as selected only when `sel_a_n`=0, `sel_b`=1 and `sel_c_n`=0. A cycle with a strobe present but no selection is a deselect: `cyc_kind`=0, with no array read or write. In this check the processor strobe counts as present only when `sel_a_n`=0.
- R2: The write condition holds when `all_wr_n`=0, or when `byte_wr_en_n`=0 and at least one bit of `lane_wr_n` is 0. A continue or suspend clock is a write (`arr_wr`=1) when the write condition holds and a read (`arr_rd`=1) otherwise.
- R3: A selected cycle with `cpu_stb_n`=0 is a begin read (`cyc_kind`=2) whatever the write inputs are, and reads the external address. When `sel_a_n`=1, `cpu_stb_n` has no effect.
- R4: A selected cycle with `ctl_stb_n`=0, `cpu_stb_n` not starting a read and the write condition true is a begin write (`cyc_kind`=3). It writes `wdata` at the external address on that edge. Without the write condition it is a begin read.
- R5: `arr_lane_we[0]` writes bits 8:0 and `arr_lane_we[1]` writes bits 17:9. With `all_wr_n`=0 both lanes are written. Otherwise lane i is written when `lane_wr_n[i]`=0.
- R6: With both strobes inactive inside an active burst, `step_n`=0 gives continue (`cyc_kind`=4) at the next burst address. `step_n`=1 gives suspend (`cyc_kind`=5) at the current address.
- R7: The burst address keeps the upper bits of the start address. When `linear_mode`=1 the two low bits are start+count mod 4. When `linear_mode`=0 they are start XOR count. The count is 0 at the start and goes up by one per continue.
- R8: When `sleep`=1, `cyc_kind`=1, no array access happens, `q_oe` is 0, all other inputs are ignored and any burst ends.
- R9: A read cycle captures the addressed word into `q` on its clock edge. The word stays on `q` until the next read cycle.
- R10: `q_oe` is 1 only while the previous clock edge sampled a read, `out_en_n`=0, the present cycle is not a write and `sleep`=0. `out_en_n` acts without a clock.
- R11: After a deselect is sampled, `q_oe` is 0 from the next edge. Strobe-free cycles that follow stay deselect (`cyc_kind`=0) until a new begin.
- R12: During and after reset no burst is active and `q_oe` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_a_n | input | 1 | Chip enable A, active low; also qualifies the processor strobe |
| sel_b | input | 1 | Chip enable B, active high |
| sel_c_n | input | 1 | Chip enable C, active low |
| cpu_stb_n | input | 1 | Processor address strobe, active low, always starts a read |
| ctl_stb_n | input | 1 | Controller address strobe, active low |
| step_n | input | 1 | Burst advance, active low |
| all_wr_n | input | 1 | Global write, active low |
| byte_wr_en_n | input | 1 | Byte-write enable, active low |
| lane_wr_n | input | 2 | Per-lane byte-write selects, active low |
| sleep | input | 1 | Sleep request, active high |
| out_en_n | input | 1 | Output enable, active low, not clocked |
| linear_mode | input | 1 | 1 = linear burst order, 0 = interleaved |
| addr | input | 6 | External word address |
| wdata | input | 18 | Write data |
| cyc_kind | output | 3 | Cycle code: 0 deselect, 1 sleep, 2 begin read, 3 begin write, 4 continue, 5 suspend |
| arr_rd | output | 1 | Array read strobe |
| arr_wr | output | 1 | Array write strobe |
| arr_lane_we | output | 2 | Array per-lane write enables |
| arr_addr | output | 6 | Array address for this cycle |
| q | output | 18 | Registered read data |
| q_oe | output | 1 | Data-bus drive enable |

## Verification
The hardest case to reach from the ports is a write that follows a processor-strobe start. It needs a begin read with the write inputs already asserted, followed by a strobe-free clock inside the still-active burst. Random stimulus seldom lines these up. So the bench drives that sequence directly, then checks that the written word shows up at the advanced burst address on a later read. Interrupted bursts, lane-masked writes and deselects during a burst are also driven directly. Long random runs in both burst orders follow, with output enable and sleep toggling.

// File: rtl/sbc_pkg.sv
package sbc_pkg;
  typedef enum logic [2:0] {
    CYC_DESEL    = 3'd0,
    CYC_SLEEP    = 3'd1,
    CYC_BEGIN_RD = 3'd2,
    CYC_BEGIN_WR = 3'd3,
    CYC_CONT     = 3'd4,
    CYC_SUSP     = 3'd5
  } cyc_e;
endpackage

// File: rtl/sbc_decode.sv
module sbc_decode
  import sbc_pkg::*;
#(
  parameter int LANES = 2
) (
  input  logic             sel_a_n,
  input  logic             sel_b,
  input  logic             sel_c_n,
  input  logic             cpu_stb_n,
  input  logic             ctl_stb_n,
  input  logic             step_n,
  input  logic             all_wr_n,
  input  logic             byte_wr_en_n,
  input  logic [LANES-1:0] lane_wr_n,
  input  logic             sleep,
  input  logic             active,
  output cyc_e             kind,
  output logic             rd,
  output logic             wr,
  output logic [LANES-1:0] lane_we
);
  logic selected, wcond, cpu_go, ctl_go, mid_burst;

  assign selected = !sel_a_n && sel_b && !sel_c_n;
  assign wcond    = !all_wr_n || (!byte_wr_en_n && (lane_wr_n != '1));
  assign cpu_go   = !cpu_stb_n && !sel_a_n;
  assign ctl_go   = !ctl_stb_n;

  always_comb begin
    kind = CYC_DESEL;
    if (sleep)                  kind = CYC_SLEEP;
    else if (cpu_go || ctl_go) begin
      if (!selected)            kind = CYC_DESEL;
      else if (cpu_go)          kind = CYC_BEGIN_RD;
      else if (wcond)           kind = CYC_BEGIN_WR;
      else                      kind = CYC_BEGIN_RD;
    end
    else if (active)            kind = step_n ? CYC_SUSP : CYC_CONT;
  end

  assign mid_burst = (kind == CYC_CONT) || (kind == CYC_SUSP);
  assign wr = (kind == CYC_BEGIN_WR) || (mid_burst && wcond);
  assign rd = (kind == CYC_BEGIN_RD) || (mid_burst && !wcond);

  always_comb begin
    lane_we = '0;
    if (wr) lane_we = all_wr_n ? ~lane_wr_n : '1;
  end
endmodule

// File: rtl/sbc_burst.sv
module sbc_burst
  import sbc_pkg::*;
#(
  parameter int AW = 6,
  parameter int BB = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  cyc_e          kind,
  input  logic          linear,
  input  logic [AW-1:0] ext_addr,
  output logic [AW-1:0] eff_addr
);
  logic [AW-1:0] base_q, base_d;
  logic [BB-1:0] cnt_q, cnt_d, pick, low;
  logic          start, adv_en;

  assign start  = (kind == CYC_BEGIN_RD) || (kind == CYC_BEGIN_WR);
  assign adv_en = start || (kind == CYC_CONT);

  always_comb begin
    base_d = base_q;
    cnt_d  = cnt_q;
    if (start) begin
      base_d = ext_addr;
      cnt_d  = '0;
    end else if (kind == CYC_CONT) begin
      cnt_d  = cnt_q + BB'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      cnt_q  <= '0;
    end else if (adv_en) begin
      base_q <= base_d;
      cnt_q  <= cnt_d;
    end
  end

  always_comb begin
    pick = (kind == CYC_CONT) ? cnt_q + BB'(1) : cnt_q;
    low  = linear ? base_q[BB-1:0] + pick : base_q[BB-1:0] ^ pick;
    eff_addr = start ? ext_addr : {base_q[AW-1:BB], low};
  end

  // R6: a suspend reuses the address of the cycle before it
  assert_susp_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == CYC_SUSP && $stable(linear)) |-> eff_addr == $past(eff_addr));
  // R7: in linear order a continue steps the low bits by one
  assert_linear_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == CYC_CONT && linear && $past(linear))
      |-> eff_addr[BB-1:0] == $past(eff_addr[BB-1:0]) + BB'(1));
endmodule

// File: rtl/sbc_store.sv
module sbc_store #(
  parameter int AW     = 6,
  parameter int LANES  = 2,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic [AW-1:0]           addr,
  input  logic [LANES*LANE_W-1:0] wdata,
  input  logic [LANES-1:0]        lane_we,
  output logic [LANES*LANE_W-1:0] rword
);
  localparam int DEPTH = 1 << AW;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] cells [DEPTH];
    always_ff @(posedge clk) begin
      if (lane_we[g]) cells[addr] <= wdata[g*LANE_W +: LANE_W];
    end
    assign rword[g*LANE_W +: LANE_W] = cells[addr];
  end
endmodule

// File: rtl/sbsram_ctl.sv
module sbsram_ctl
  import sbc_pkg::*;
#(
  parameter int AW     = 6,
  parameter int LANES  = 2,
  parameter int LANE_W = 9,
  parameter int BB     = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    sel_a_n,
  input  logic                    sel_b,
  input  logic                    sel_c_n,
  input  logic                    cpu_stb_n,
  input  logic                    ctl_stb_n,
  input  logic                    step_n,
  input  logic                    all_wr_n,
  input  logic                    byte_wr_en_n,
  input  logic [LANES-1:0]        lane_wr_n,
  input  logic                    sleep,
  input  logic                    out_en_n,
  input  logic                    linear_mode,
  input  logic [AW-1:0]           addr,
  input  logic [LANES*LANE_W-1:0] wdata,
  output logic [2:0]              cyc_kind,
  output logic                    arr_rd,
  output logic                    arr_wr,
  output logic [LANES-1:0]        arr_lane_we,
  output logic [AW-1:0]           arr_addr,
  output logic [LANES*LANE_W-1:0] q,
  output logic                    q_oe
);
  localparam int WORD_W = LANES * LANE_W;

  logic [1:0]        rst_pipe;
  logic              rst_q;
  cyc_e              kind;
  logic              active_q, active_d, drive_q;
  logic [WORD_W-1:0] rword;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_q = rst_pipe[1];

  sbc_decode #(.LANES(LANES)) u_decode (
    .sel_a_n(sel_a_n), .sel_b(sel_b), .sel_c_n(sel_c_n),
    .cpu_stb_n(cpu_stb_n), .ctl_stb_n(ctl_stb_n), .step_n(step_n),
    .all_wr_n(all_wr_n), .byte_wr_en_n(byte_wr_en_n), .lane_wr_n(lane_wr_n),
    .sleep(sleep), .active(active_q), .kind(kind),
    .rd(arr_rd), .wr(arr_wr), .lane_we(arr_lane_we)
  );

  sbc_burst #(.AW(AW), .BB(BB)) u_burst (
    .clk(clk), .rst_n(rst_q), .kind(kind), .linear(linear_mode),
    .ext_addr(addr), .eff_addr(arr_addr)
  );

  sbc_store #(.AW(AW), .LANES(LANES), .LANE_W(LANE_W)) u_store (
    .clk(clk), .addr(arr_addr), .wdata(wdata),
    .lane_we(arr_lane_we), .rword(rword)
  );

  always_comb begin
    active_d = active_q;
    case (kind)
      CYC_BEGIN_RD, CYC_BEGIN_WR: active_d = 1'b1;
      CYC_DESEL, CYC_SLEEP:       active_d = 1'b0;
      default:                    active_d = active_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      active_q <= 1'b0;
      drive_q  <= 1'b0;
    end else begin
      active_q <= active_d;
      drive_q  <= arr_rd;
    end
  end

  always_ff @(posedge clk) begin
    if (arr_rd) q <= rword;
  end

  assign cyc_kind = kind;
  assign q_oe     = drive_q && !out_en_n && !arr_wr && !sleep;

  // R3: a selected processor strobe is always a read
  assert_cpu_read_R3: assert property (@(posedge clk) disable iff (!rst_q)
    (!sleep && !cpu_stb_n && !sel_a_n && sel_b && !sel_c_n) |-> (arr_rd && !arr_wr));
  // R8: sleep blocks every access and the bus
  assert_sleep_quiet_R8: assert property (@(posedge clk) disable iff (!rst_q)
    sleep |-> (!arr_rd && !arr_wr && arr_lane_we == '0 && !q_oe));
  // R11: a deselect releases the bus on the next clock
  assert_release_R11: assert property (@(posedge clk) disable iff (!rst_q)
    (cyc_kind == 3'd0) |=> !q_oe);
  // R10: output enable high keeps the bus released
  assert_oe_gate_R10: assert property (@(posedge clk) disable iff (!rst_q)
    out_en_n |-> !q_oe);
  // R5: lane enables only appear on a write
  assert_lane_on_write_R5: assert property (@(posedge clk) disable iff (!rst_q)
    (arr_lane_we != '0) |-> arr_wr);
endmodule

// File: tb/sbsram_ctl_bench.sv
module sbsram_ctl_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        sel_a_n, sel_b, sel_c_n, cpu_stb_n, ctl_stb_n, step_n;
  logic        all_wr_n, byte_wr_en_n, sleep, out_en_n, linear_mode;
  logic [1:0]  lane_wr_n;
  logic [5:0]  addr;
  logic [17:0] wdata;
  logic [2:0]  cyc_kind;
  logic        arr_rd, arr_wr, q_oe;
  logic [1:0]  arr_lane_we;
  logic [5:0]  arr_addr;
  logic [17:0] q;

  int n_checks = 0;
  int n_fail   = 0;

  logic [17:0] m_mem [64];
  logic        m_active, m_drive;
  logic [5:0]  m_base;
  logic [1:0]  m_cnt;
  logic [17:0] m_q;

  always #4 clk = ~clk;

  sbsram_ctl u_sbsram_ctl (
    .clk(clk), .rst_n(rst_n), .sel_a_n(sel_a_n), .sel_b(sel_b), .sel_c_n(sel_c_n),
    .cpu_stb_n(cpu_stb_n), .ctl_stb_n(ctl_stb_n), .step_n(step_n),
    .all_wr_n(all_wr_n), .byte_wr_en_n(byte_wr_en_n), .lane_wr_n(lane_wr_n),
    .sleep(sleep), .out_en_n(out_en_n), .linear_mode(linear_mode),
    .addr(addr), .wdata(wdata), .cyc_kind(cyc_kind), .arr_rd(arr_rd),
    .arr_wr(arr_wr), .arr_lane_we(arr_lane_we), .arr_addr(arr_addr),
    .q(q), .q_oe(q_oe)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic string kind_req(input int k);
    case (k)
      0: return "R1";
      1: return "R8";
      2: return "R3";
      3: return "R4";
      default: return "R6";
    endcase
  endfunction

  function automatic logic [5:0] burst_addr(input logic [1:0] c);
    logic [1:0] lo;
    lo = linear_mode ? m_base[1:0] + c : m_base[1:0] ^ c;
    return {m_base[5:2], lo};
  endfunction

  task automatic idle();
    sel_a_n = 0; sel_b = 1; sel_c_n = 0; cpu_stb_n = 1; ctl_stb_n = 1;
    step_n = 1; all_wr_n = 1; byte_wr_en_n = 1; lane_wr_n = 2'b11;
    sleep = 0; out_en_n = 0;
  endtask

  // Apply one vector: inputs already set at the falling edge
  task automatic tick();
    bit sel, wc, cgo, kgo, erd, ewr;
    int ek;
    logic [1:0]  el;
    logic [5:0]  ea;
    logic        eoe;
    #2;
    sel = !sel_a_n && sel_b && !sel_c_n;
    wc  = !all_wr_n || (!byte_wr_en_n && lane_wr_n != 2'b11);
    cgo = !cpu_stb_n && !sel_a_n;
    kgo = !ctl_stb_n;
    if (sleep) ek = 1;
    else if (cgo || kgo) ek = !sel ? 0 : (cgo ? 2 : (wc ? 3 : 2));
    else if (m_active) ek = step_n ? 5 : 4;
    else ek = 0;
    ewr = (ek == 3) || ((ek == 4 || ek == 5) && wc);
    erd = (ek == 2) || ((ek == 4 || ek == 5) && !wc);
    el  = ewr ? (!all_wr_n ? 2'b11 : ~lane_wr_n) : 2'b00;
    ea  = (ek == 2 || ek == 3) ? addr : (ek == 4 ? burst_addr(m_cnt + 2'd1) : burst_addr(m_cnt));
    eoe = m_drive && !out_en_n && !ewr && !sleep;

    check(int'(cyc_kind) == ek, kind_req(ek), "cycle kind", int'(cyc_kind), ek);
    check(arr_rd == erd && arr_wr == ewr, "R2", "rd/wr strobes", {arr_rd, arr_wr}, {erd, ewr});
    check(arr_lane_we == el, "R5", "lane enables", arr_lane_we, el);
    if (erd || ewr) check(arr_addr == ea, "R7", "array address", arr_addr, ea);
    check(q_oe == eoe, "R10", "bus enable", q_oe, eoe);
    if (eoe) check(q == m_q, "R9", "read data", q, m_q);

    @(posedge clk);
    if (el[0]) m_mem[ea][8:0]  = wdata[8:0];
    if (el[1]) m_mem[ea][17:9] = wdata[17:9];
    if (erd) m_q = m_mem[ea];
    m_drive = erd;
    if (ek == 2 || ek == 3) begin m_active = 1; m_base = addr; m_cnt = 0; end
    else if (ek == 4) m_cnt = m_cnt + 2'd1;
    else if (ek == 0 || ek == 1) m_active = 0;
    @(negedge clk);
  endtask

  initial begin
    #(8 * 150000);
    n_fail++;
    $display("FAIL R12 watchdog actual=timeout expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    idle(); linear_mode = 1; addr = 0; wdata = 0;
    m_active = 0; m_drive = 0; m_base = 0; m_cnt = 0; m_q = 0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    check(q_oe == 1'b0, "R12", "bus enable in reset", q_oe, 0);
    rst_n = 1;
    repeat (3) @(negedge clk);
    check(q_oe == 1'b0 && cyc_kind == 3'd0, "R12", "idle after reset",
          {q_oe, cyc_kind}, 0);

    // fill the store through controller-strobe writes
    for (int a = 0; a < 64; a++) begin
      idle(); ctl_stb_n = 0; all_wr_n = 0; addr = 6'(a);
      wdata = 18'($urandom); tick();
    end

    // write that follows a processor-strobe start (R3, R6)
    idle(); cpu_stb_n = 0; all_wr_n = 0; addr = 6'd5; wdata = 18'h3ffff; tick();
    idle(); step_n = 0; all_wr_n = 0; wdata = 18'h2a5a5; tick();
    idle(); step_n = 1; tick();
    idle(); cpu_stb_n = 0; addr = 6'd6; tick();
    idle(); tick();
    check(q == 18'h2a5a5, "R6", "word written after processor start", q, 18'h2a5a5);

    // lane-masked write: only low lane (R5)
    idle(); ctl_stb_n = 0; byte_wr_en_n = 0; lane_wr_n = 2'b10; addr = 6'd9;
    wdata = 18'h15555; tick();
    idle(); cpu_stb_n = 0; addr = 6'd9; tick();
    idle(); tick();
    // high lane only
    idle(); ctl_stb_n = 0; byte_wr_en_n = 0; lane_wr_n = 2'b01; addr = 6'd9;
    wdata = 18'h0aaaa; tick();
    idle(); cpu_stb_n = 0; addr = 6'd9; tick();
    idle(); tick();

    // interrupted burst, interleaved order (R7)
    linear_mode = 0;
    idle(); cpu_stb_n = 0; addr = 6'd14; tick();
    idle(); step_n = 0; tick();
    idle(); ctl_stb_n = 0; addr = 6'd31; tick();
    idle(); step_n = 0; tick();
    idle(); tick();
    idle(); step_n = 0; tick();
    linear_mode = 1;

    // deselect inside a burst, then strobe-free cycles (R11)
    idle(); cpu_stb_n = 0; addr = 6'd40; tick();
    idle(); ctl_stb_n = 0; sel_b = 0; tick();
    idle(); step_n = 0; tick();
    check(q_oe == 1'b0, "R11", "bus after deselect", q_oe, 0);

    // processor strobe ignored when sel_a_n high (R3)
    idle(); sel_a_n = 1; cpu_stb_n = 0; addr = 6'd2; tick();

    // sleep during a burst (R8)
    idle(); cpu_stb_n = 0; addr = 6'd20; tick();
    idle(); sleep = 1; ctl_stb_n = 0; all_wr_n = 0; tick();
    idle(); step_n = 0; tick();

    // output enable toggling during a read burst (R10)
    idle(); cpu_stb_n = 0; addr = 6'd50; tick();
    idle(); step_n = 0; out_en_n = 1; tick();
    idle(); step_n = 0; tick();

    // constrained random
    for (int i = 0; i < 4000; i++) begin
      if (i % 1000 == 0) linear_mode = ~linear_mode;
      sel_a_n      = ($urandom % 10) == 0;
      sel_b        = ($urandom % 10) != 0;
      sel_c_n      = ($urandom % 10) == 0;
      cpu_stb_n    = ($urandom % 4) != 0;
      ctl_stb_n    = ($urandom % 10) > 2;
      step_n       = ($urandom % 10) > 5;
      all_wr_n     = ($urandom % 5) != 0;
      byte_wr_en_n = ($urandom % 5) > 1;
      lane_wr_n    = 2'($urandom);
      sleep        = ($urandom % 30) == 0;
      out_en_n     = ($urandom % 5) == 0;
      addr         = 6'($urandom);
      wdata        = 18'($urandom);
      tick();
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule